// File: doc/BRIEF.md
# Two-Wire Potentiometer Command Slave

This block is the bus-facing half of a digital potentiometer. It watches a two-wire open-drain bus (a clock line and a data line) with the system clock. It finds start and stop conditions and checks the slave address against three strap inputs. It decodes a one-byte instruction and either moves a 6-bit value across the bus or hands a command straight to the register core. The core sits beside this block and holds the wiper register and the stored settings. The block tells the core what to do with a one-cycle request: an operation code, a 2-bit register pointer and a 6-bit payload. The core answers reads through a 6-bit `rd_data` input.

The slave pulls the data line low only through `sda_oe`; the pad drives a zero when it is high and floats otherwise. A `core_busy` input from the core withholds the acknowledge on the address byte. A master can therefore poll until a slow store has finished.

Top module: `pot_bus_slave`

## Requirements
- R1: A falling data line while the clock is high is a start; it re-arms address reception at any moment, including in the middle of a transaction. A rising data line while the clock is high is a stop; it returns the slave to idle and releases `sda_oe`.
- R2: The first byte after a start is taken MSB first. It matches when its bits 7..4 are 0101, bit 3 equals `strap[2]`, bit 2 equals `strap[1]`, bit 1 is 0 and bit 0 equals `strap[0]`. On a match the slave holds `sda_oe` high through the ninth clock.
- R3: On an address mismatch, or with `core_busy` high when the address byte completes, the ninth clock is not acknowledged. No later byte is acknowledged and no request is issued until the next start.
- R4: The second byte carries the opcode in bits 7..4, the register pointer in bits 3..2 and two reserved bits 1..0. Accepted opcodes are 1001, 1010, 1011, 1100, 1101, 1110 and 0010. The byte is acknowledged only for an accepted opcode with both reserved bits zero; otherwise nothing is acknowledged or requested until the next start.
- R5: Opcode 1001 issues `req_op`=1 and opcode 1011 issues `req_op`=3, at the eighth falling clock of the instruction byte. The slave samples `rd_data` as the instruction acknowledge ends and sends {00, rd_data} MSB first. It then releases the line for the master's acknowledge and ignores the bus until the next start.
- R6: Opcodes 1010 and 1100 acknowledge a third byte. At that byte's eighth falling clock they issue `req_op`=2 or 4 with `req_wdata` equal to the byte's low six bits; the two upper bits are ignored.
- R7: Opcodes 1101 and 1110 issue `req_op`=5 or 6 at the eighth falling clock of the instruction byte. Any byte that follows is not acknowledged.
- R8: After opcode 0010 is acknowledged, each further clock issues `req_op`=7 at its falling edge. `req_wdata` is 1 when the data line was high at the rising edge (step up) and 0 when it was low (step down). A clock whose high phase ends in a stop issues nothing.
- R9: A start or stop before the eighth bit of a byte discards its bits and issues no request for it.
- R10: `req_valid` is a one-cycle pulse, and `req_ptr` carries instruction bits 3..2.
- R11: After reset `sda_oe` and `req_valid` are low, and `sda_oe` changes only while the synchronized clock line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| strap | input | 3 | Address straps, matched against address bits 3, 2 and 0 |
| core_busy | input | 1 | Register core busy; withholds the address acknowledge |
| rd_data | input | 6 | Value returned by the core for read requests |
| sda_oe | output | 1 | Pull the data line low when high |
| req_valid | output | 1 | One-cycle request strobe to the core |
| req_op | output | 3 | Request code: 1 read wiper, 2 write wiper, 3 read store, 4 write store, 5 load wiper, 6 save wiper, 7 step |
| req_ptr | output | 2 | Register pointer from the instruction byte |
| req_wdata | output | 6 | Write payload, or step direction in bit 0 |

## Verification
Every result follows an edge on the bus clock line. That edge passes two synchronizer flops and one edge-detect flop, so `sda_oe` and `req_valid` change three system cycles after the pin moves. The bench holds each bus-clock phase for ten system cycles and reads the acknowledge and the read bits in the middle of the high phase, well past that three-cycle delay. A monitor counts every request pulse, so request checks are made after the stop and do not depend on the exact cycle.

// File: rtl/pot_bus_pkg.sv
package pot_bus_pkg;

    typedef enum logic [2:0] {
        PH_IDLE, PH_ADDR, PH_INSTR, PH_WDATA, PH_RDATA, PH_STEP, PH_IGNORE
    } phase_e;

    typedef enum logic [2:0] {
        RQ_NONE       = 3'd0,
        RQ_RD_WIPER   = 3'd1,
        RQ_WR_WIPER   = 3'd2,
        RQ_RD_STORE   = 3'd3,
        RQ_WR_STORE   = 3'd4,
        RQ_LOAD_WIPER = 3'd5,
        RQ_SAVE_WIPER = 3'd6,
        RQ_STEP       = 3'd7
    } req_e;

    localparam logic [3:0] TYPE_NIBBLE = 4'b0101;

endpackage

// File: rtl/bus_line_sync.sv
module bus_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic [STAGES-1:0] scl_pipe_q, sda_pipe_q;
    logic              scl_prev_q, sda_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe_q <= '1;
            sda_pipe_q <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_pipe_q <= {scl_pipe_q[STAGES-2:0], scl_i};
            sda_pipe_q <= {sda_pipe_q[STAGES-2:0], sda_i};
            scl_prev_q <= scl_pipe_q[STAGES-1];
            sda_prev_q <= sda_pipe_q[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe_q[STAGES-1];
    assign sda_s     = sda_pipe_q[STAGES-1];
    assign scl_rise  = scl_s & ~scl_prev_q;
    assign scl_fall  = ~scl_s & scl_prev_q;
    assign start_evt = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
    assign stop_evt  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
endmodule

// File: rtl/addr_match.sv
module addr_match (
    input  logic [7:0] abyte,
    input  logic [2:0] strap,
    input  logic       core_busy,
    output logic       ack_ok
);
    import pot_bus_pkg::*;
    logic hit;
    assign hit = (abyte[7:4] == TYPE_NIBBLE) && (abyte[3] == strap[2]) &&
                 (abyte[2] == strap[1]) && !abyte[1] && (abyte[0] == strap[0]);
    assign ack_ok = hit && !core_busy;
endmodule

// File: rtl/op_decode.sv
module op_decode (
    input  logic [7:0] ibyte,
    output logic [2:0] op,
    output logic [2:0] next_phase,
    output logic       ok,
    output logic       issue_now
);
    import pot_bus_pkg::*;
    req_e   op_v;
    phase_e nx_v;

    always_comb begin
        op_v = RQ_NONE;
        nx_v = PH_IGNORE;
        case (ibyte[7:4])
            4'b1001: begin op_v = RQ_RD_WIPER;   nx_v = PH_RDATA;  end
            4'b1010: begin op_v = RQ_WR_WIPER;   nx_v = PH_WDATA;  end
            4'b1011: begin op_v = RQ_RD_STORE;   nx_v = PH_RDATA;  end
            4'b1100: begin op_v = RQ_WR_STORE;   nx_v = PH_WDATA;  end
            4'b1101: begin op_v = RQ_LOAD_WIPER; nx_v = PH_IGNORE; end
            4'b1110: begin op_v = RQ_SAVE_WIPER; nx_v = PH_IGNORE; end
            4'b0010: begin op_v = RQ_STEP;       nx_v = PH_STEP;   end
            default: begin op_v = RQ_NONE;       nx_v = PH_IGNORE; end
        endcase
    end

    assign op         = op_v;
    assign next_phase = nx_v;
    assign ok         = (op_v != RQ_NONE) && (ibyte[1:0] == 2'b00);
    assign issue_now  = ok && (op_v inside {RQ_RD_WIPER, RQ_RD_STORE,
                                           RQ_LOAD_WIPER, RQ_SAVE_WIPER});
endmodule

// File: rtl/pot_bus_slave.sv
module pot_bus_slave #(
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = 6,
    parameter int PTR_W       = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [2:0]        strap,
    input  logic              core_busy,
    input  logic [DATA_W-1:0] rd_data,
    output logic              sda_oe,
    output logic              req_valid,
    output logic [2:0]        req_op,
    output logic [PTR_W-1:0]  req_ptr,
    output logic [DATA_W-1:0] req_wdata
);
    import pot_bus_pkg::*;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 2);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    typedef struct packed {
        phase_e             phase;
        phase_e             nxt;
        logic               ack_slot;
        logic [CNT_W-1:0]   cnt;
        logic [BYTE_W-1:0]  sh;
        logic               oe;
        req_e               op;
        logic [PTR_W-1:0]   ptr;
        logic               step_pend;
        logic               step_up;
        logic               req_v;
        req_e               req_op;
        logic [PTR_W-1:0]   req_ptr;
        logic [DATA_W-1:0]  req_data;
    } st_t;

    st_t st_d, st_q;

    logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
    logic addr_ok, op_ok, op_issue, addr_done;
    logic [2:0] dec_op, dec_nx;
    logic [BYTE_W-1:0] rd_byte;

    bus_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_evt(start_evt), .stop_evt(stop_evt)
    );

    addr_match u_addr (
        .abyte(st_q.sh), .strap(strap), .core_busy(core_busy), .ack_ok(addr_ok)
    );

    op_decode u_dec (
        .ibyte(st_q.sh), .op(dec_op), .next_phase(dec_nx), .ok(op_ok),
        .issue_now(op_issue)
    );

    assign rd_byte = BYTE_W'(rd_data);

    always_comb begin
        st_d      = st_q;
        st_d.req_v = 1'b0;
        addr_done = 1'b0;
        if (stop_evt || start_evt) begin
            st_d.phase     = stop_evt ? PH_IDLE : PH_ADDR;
            st_d.ack_slot  = 1'b0;
            st_d.oe        = 1'b0;
            st_d.cnt       = '0;
            st_d.step_pend = 1'b0;
        end else if (scl_rise) begin
            case (st_q.phase)
                PH_ADDR, PH_INSTR, PH_WDATA: begin
                    if (!st_q.ack_slot && st_q.cnt < LAST_BIT) begin
                        st_d.sh  = {st_q.sh[BYTE_W-2:0], sda_s};
                        st_d.cnt = st_q.cnt + 1'b1;
                    end
                end
                PH_RDATA: if (!st_q.ack_slot) st_d.cnt = st_q.cnt + 1'b1;
                PH_STEP: begin
                    st_d.step_pend = 1'b1;
                    st_d.step_up   = sda_s;
                end
                default: ;
            endcase
        end else if (scl_fall) begin
            if (st_q.ack_slot) begin
                st_d.ack_slot = 1'b0;
                st_d.cnt      = '0;
                st_d.phase    = st_q.nxt;
                st_d.oe       = 1'b0;
                if (st_q.nxt == PH_RDATA) begin
                    st_d.sh = rd_byte;
                    st_d.oe = ~rd_byte[BYTE_W-1];
                end
            end else begin
                case (st_q.phase)
                    PH_ADDR: if (st_q.cnt == LAST_BIT) begin
                        addr_done     = 1'b1;
                        st_d.ack_slot = 1'b1;
                        st_d.oe       = addr_ok;
                        st_d.nxt      = addr_ok ? PH_INSTR : PH_IGNORE;
                    end
                    PH_INSTR: if (st_q.cnt == LAST_BIT) begin
                        st_d.ack_slot = 1'b1;
                        st_d.oe       = op_ok;
                        st_d.nxt      = op_ok ? phase_e'(dec_nx) : PH_IGNORE;
                        st_d.op       = req_e'(dec_op);
                        st_d.ptr      = st_q.sh[3:2];
                        if (op_issue) begin
                            st_d.req_v    = 1'b1;
                            st_d.req_op   = req_e'(dec_op);
                            st_d.req_ptr  = st_q.sh[3:2];
                            st_d.req_data = '0;
                        end
                    end
                    PH_WDATA: if (st_q.cnt == LAST_BIT) begin
                        st_d.ack_slot = 1'b1;
                        st_d.oe       = 1'b1;
                        st_d.nxt      = PH_IGNORE;
                        st_d.req_v    = 1'b1;
                        st_d.req_op   = st_q.op;
                        st_d.req_ptr  = st_q.ptr;
                        st_d.req_data = st_q.sh[DATA_W-1:0];
                    end
                    PH_RDATA: begin
                        if (st_q.cnt == LAST_BIT) begin
                            st_d.ack_slot = 1'b1;
                            st_d.oe       = 1'b0;
                            st_d.nxt      = PH_IGNORE;
                        end else begin
                            st_d.sh = {st_q.sh[BYTE_W-2:0], 1'b0};
                            st_d.oe = ~st_q.sh[BYTE_W-2];
                        end
                    end
                    PH_STEP: if (st_q.step_pend) begin
                        st_d.step_pend = 1'b0;
                        st_d.req_v     = 1'b1;
                        st_d.req_op    = RQ_STEP;
                        st_d.req_ptr   = st_q.ptr;
                        st_d.req_data  = DATA_W'(st_q.step_up);
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, nxt: PH_IDLE, op: RQ_NONE, req_op: RQ_NONE,
                      default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sda_oe    = st_q.oe;
    assign req_valid = st_q.req_v;
    assign req_op    = st_q.req_op;
    assign req_ptr   = st_q.req_ptr;
    assign req_wdata = st_q.req_data;
endmodule

// File: rtl/pot_bus_slave_chk.sv
module pot_bus_slave_chk #(
    parameter int DATA_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_s,
    input logic              stop_evt,
    input logic              addr_done,
    input logic              core_busy,
    input logic              sda_oe,
    input logic              req_valid,
    input logic [2:0]        req_op,
    input logic [DATA_W-1:0] req_wdata
);
    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);                                   // R10

    AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        addr_done && core_busy |=> !sda_oe);                         // R3

    AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_oe);                                       // R1

    AST_OE_QUIET_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        scl_s && $past(scl_s) |-> $stable(sda_oe));                  // R11

    AST_STEP_DIR_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_op == 3'd7 |-> req_wdata[DATA_W-1:1] == '0); // R8

    AST_NO_REQ_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !req_valid);                                    // R9
endmodule

bind pot_bus_slave pot_bus_slave_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .stop_evt(stop_evt),
    .addr_done(addr_done), .core_busy(core_busy), .sda_oe(sda_oe),
    .req_valid(req_valid), .req_op(req_op), .req_wdata(req_wdata)
);

// File: tb/tb_pot_bus_slave.sv
module tb_pot_bus_slave;
    localparam int HALF = 10;
    localparam logic [7:0] ADDR = 8'h59;   // straps 3'b101
    localparam logic [5:0] RDV  = 6'h2D;

    typedef struct packed {
        logic       busy;
        logic [7:0] abyte;
        logic [7:0] ibyte;
        logic [7:0] dbyte;
        logic [1:0] kind;     // 0 two bytes, 1 three bytes written, 2 read
        logic [2:0] eack;     // {addr, instr, third}
        logic [1:0] enreq;
        logic [2:0] eop;
        logic [1:0] eptr;
        logic [7:0] eval;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{1'b0, ADDR,  8'hA4, 8'h15, 2'd1, 3'b111, 2'd1, 3'd2, 2'd1, 8'h15}, // R6
        '{1'b0, ADDR,  8'hCC, 8'h3F, 2'd1, 3'b111, 2'd1, 3'd4, 2'd3, 8'h3F}, // R6
        '{1'b0, ADDR,  8'h90, 8'h00, 2'd2, 3'b110, 2'd1, 3'd1, 2'd0, 8'h2D}, // R5
        '{1'b0, ADDR,  8'hB8, 8'h00, 2'd2, 3'b110, 2'd1, 3'd3, 2'd2, 8'h2D}, // R5
        '{1'b0, ADDR,  8'hD4, 8'h00, 2'd1, 3'b110, 2'd1, 3'd5, 2'd1, 8'h00}, // R7
        '{1'b0, ADDR,  8'hE8, 8'h00, 2'd0, 3'b110, 2'd1, 3'd6, 2'd2, 8'h00}, // R7
        '{1'b1, ADDR,  8'hA4, 8'h15, 2'd1, 3'b000, 2'd0, 3'd0, 2'd0, 8'h00}, // R3
        '{1'b0, 8'h79, 8'hA4, 8'h15, 2'd1, 3'b000, 2'd0, 3'd0, 2'd0, 8'h00}, // R2
        '{1'b0, 8'h5B, 8'hA4, 8'h15, 2'd1, 3'b000, 2'd0, 3'd0, 2'd0, 8'h00}, // R2
        '{1'b0, 8'h51, 8'hA4, 8'h15, 2'd1, 3'b000, 2'd0, 3'd0, 2'd0, 8'h00}, // R3
        '{1'b0, ADDR,  8'h10, 8'h05, 2'd1, 3'b100, 2'd0, 3'd0, 2'd0, 8'h00}, // R4
        '{1'b0, ADDR,  8'hA1, 8'h05, 2'd1, 3'b100, 2'd0, 3'd0, 2'd0, 8'h00}, // R4
        '{1'b0, ADDR,  8'hA0, 8'hEA, 2'd1, 3'b111, 2'd1, 3'd2, 2'd0, 8'h2A}  // R6
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic scl = 1'b1, sda_m = 1'b1, busy = 1'b0;
    logic sda_oe, req_valid;
    logic [2:0] req_op;
    logic [1:0] req_ptr;
    logic [5:0] req_wdata;
    wire  sda_line = sda_m & ~sda_oe;

    int nvec = 0, nfail = 0;
    int req_cnt = 0, up_cnt = 0;
    logic [2:0] last_op = '0;
    logic [1:0] last_ptr = '0;
    logic [5:0] last_wd = '0;

    always #4 clk = ~clk;

    pot_bus_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .strap(3'b101), .core_busy(busy), .rd_data(RDV),
        .sda_oe(sda_oe), .req_valid(req_valid), .req_op(req_op),
        .req_ptr(req_ptr), .req_wdata(req_wdata)
    );

    always @(posedge clk) begin
        if (req_valid) begin
            req_cnt  <= req_cnt + 1;
            last_op  <= req_op;
            last_ptr <= req_ptr;
            last_wd  <= req_wdata;
            if (req_op == 3'd7 && req_wdata[0]) up_cnt <= up_cnt + 1;
        end
    end

    task automatic wcyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wcyc(HALF);
        scl = 1'b1;   wcyc(HALF);
        sda_m = 1'b0; wcyc(HALF);
        scl = 1'b0;   wcyc(HALF);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wcyc(HALF);
        scl = 1'b1;   wcyc(HALF);
        sda_m = 1'b1; wcyc(HALF);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i]; wcyc(HALF);
            scl = 1'b1;   wcyc(HALF);
            scl = 1'b0;   wcyc(2);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; wcyc(HALF);
        scl = 1'b1;   wcyc(HALF / 2);
        ack = ~sda_line; wcyc(HALF / 2);
        scl = 1'b0;   wcyc(2);
    endtask

    task automatic read_byte(output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wcyc(HALF);
            scl = 1'b1; wcyc(HALF / 2);
            b[i] = sda_line; wcyc(HALF / 2);
            scl = 1'b0; wcyc(2);
        end
        wcyc(HALF); scl = 1'b1; wcyc(HALF); scl = 1'b0; wcyc(2); // master NACK
    endtask

    task automatic step_clock(input logic up);
        sda_m = up; wcyc(HALF);
        scl = 1'b1; wcyc(HALF);
        scl = 1'b0; wcyc(2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        logic a0, a1, a2;
        logic [7:0] rb;
        int base, ubase;
        wcyc(5);
        chk("R11 reset sda_oe", 32'(sda_oe), 32'd0);
        rst_n = 1'b1;
        wcyc(5);
        chk("R11 idle sda_oe", 32'(sda_oe), 32'd0);
        chk("R11 idle req_valid", 32'(req_valid), 32'd0);

        for (int v = 0; v < NV; v++) begin
            busy = VEC[v].busy;
            base = req_cnt;
            a2 = 1'b0; rb = '0;
            bus_start();
            send_byte(VEC[v].abyte, a0);
            busy = 1'b0;
            send_byte(VEC[v].ibyte, a1);
            if (VEC[v].kind == 2'd1) send_byte(VEC[v].dbyte, a2);
            if (VEC[v].kind == 2'd2) read_byte(rb);
            bus_stop();
            wcyc(4);
            chk($sformatf("R2/R3 vec%0d addr ack", v), 32'(a0), 32'(VEC[v].eack[2]));
            chk($sformatf("R4 vec%0d instr ack", v), 32'(a1), 32'(VEC[v].eack[1]));
            if (VEC[v].kind == 2'd1)
                chk($sformatf("R6/R7 vec%0d third ack", v), 32'(a2), 32'(VEC[v].eack[0]));
            chk($sformatf("R3/R10 vec%0d request count", v), 32'(req_cnt - base),
                32'(VEC[v].enreq));
            if (VEC[v].enreq != 0) begin
                chk($sformatf("R5/R6/R7 vec%0d op", v), 32'(last_op), 32'(VEC[v].eop));
                chk($sformatf("R10 vec%0d ptr", v), 32'(last_ptr), 32'(VEC[v].eptr));
                if (VEC[v].kind == 2'd1 && VEC[v].eop inside {3'd2, 3'd4})
                    chk($sformatf("R6 vec%0d wdata", v), 32'(last_wd), 32'(VEC[v].eval));
            end
            if (VEC[v].kind == 2'd2)
                chk($sformatf("R5 vec%0d read byte", v), 32'(rb), 32'(VEC[v].eval));
        end

        // R8: step sequence up,up,down,up,down then stop
        base = req_cnt; ubase = up_cnt;
        bus_start();
        send_byte(ADDR, a0);
        send_byte(8'h28, a1);
        step_clock(1'b1); step_clock(1'b1); step_clock(1'b0);
        step_clock(1'b1); step_clock(1'b0);
        bus_stop();
        wcyc(4);
        chk("R4 step instr ack", 32'(a1), 32'd1);
        chk("R8 step count (stop clock adds none)", 32'(req_cnt - base), 32'd5);
        chk("R8 step ups", 32'(up_cnt - ubase), 32'd3);
        chk("R8 step op", 32'(last_op), 32'd7);
        chk("R10 step ptr", 32'(last_ptr), 32'd2);
        chk("R8 last step down", 32'(last_wd), 32'd0);

        // R9/R1: repeated start inside address byte, then a full write
        base = req_cnt;
        bus_start();
        send_bits(ADDR, 4);
        bus_start();
        send_byte(ADDR, a0);
        send_byte(8'hA8, a1);
        send_byte(8'h07, a2);
        bus_stop();
        wcyc(4);
        chk("R1 restart addr ack", 32'(a0), 32'd1);
        chk("R9 restart request count", 32'(req_cnt - base), 32'd1);
        chk("R9 restart wdata", 32'(last_wd), 32'd7);
        chk("R10 restart ptr", 32'(last_ptr), 32'd2);

        // R9: stop inside data byte discards it
        base = req_cnt;
        bus_start();
        send_byte(ADDR, a0);
        send_byte(8'hA4, a1);
        send_bits(8'h3C, 4);
        bus_stop();
        wcyc(4);
        chk("R9 partial data no request", 32'(req_cnt - base), 32'd0);
        chk("R1 stop leaves line released", 32'(sda_oe), 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule